// File: doc/BRIEF.md
# Byte Window Aligner

This block joins two vector operands into one byte string of twice the operand width and returns a contiguous window of that string. The window is one operand wide and starts at a byte offset given by a count. The first operand forms the upper half of the string and the second operand the lower half. Shifting the window upward therefore moves bytes of the first operand into the places that bytes of the second operand leave, rather than filling those places with zeros. Typical uses are realigning a stream that crosses a vector boundary and extracting a misaligned field that spans two registers.

Two operand widths are supported. A wide operation works on full 128-bit operands and returns its result two clocks after it is issued. A narrow operation uses only the low 64 bits of each operand and returns its result one clock after it is issued. A new operation of either kind may be issued on every clock, except that a narrow operation may not follow a wide one in the very next clock, because both results would then arrive in the same cycle.

Top module: `alignr_unit`

## Requirements
- R1: In wide mode (`in_mode` = 1), result byte i (bits 8i+7..8i) equals byte (count + i) of the 32-byte string whose bytes 0..15 are `in_lo` and bytes 16..31 are `in_hi`. A count of 0 returns `in_lo` and a count of 16 returns `in_hi`.
- R2: A wide operation accepted on one rising edge raises `out_valid` with its result two rising edges later.
- R3: In narrow mode (`in_mode` = 0), only `in_hi[63:0]` and `in_lo[63:0]` are used. They form a 16-byte string with `in_lo[63:0]` as bytes 0..7, and result byte i for i in 0..7 equals byte (count + i) of that string. The result appears one rising edge after the operation is accepted.
- R4: A narrow result has bits 127..64 equal to zero, whatever the upper halves of the operands hold.
- R5: String positions at or above the top of the string read as zero. A count of at least 32 (wide) or at least 16 (narrow) gives an all-zero result, and a count between the operand width and twice the width gives zeros in the upper result bytes.
- R6: The count is an 8-bit unsigned number that is never reduced modulo any width. For example, a wide count of 33 or 255 gives zero and does not act as a count of 1 or 31.
- R7: Every accepted operation produces exactly one cycle with `out_valid` high, and `out_valid` is never high without a matching operation. Back-to-back operations, one per clock, each produce their own result in order.
- R8: While `rst` is high and afterwards, `out_data` is all zeros in every cycle in which `out_valid` is low. After reset, `out_valid` is low until the first result.
- R9: Issuing a narrow operation in the clock immediately after a wide one is a usage error. Any other spacing, including a narrow operation two clocks after a wide one, delivers both results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_mode | input | 1 | Operand width: 1 = 128-bit (wide), 0 = 64-bit (narrow) |
| in_count | input | 8 | Unsigned byte offset of the window |
| in_hi | input | 128 | First operand, forms the upper half of the string |
| in_lo | input | 128 | Second operand, forms the lower half of the string |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 128 | Extracted window; zero when no result is present |

## Verification
The operand bytes carry distinct, position-coded values, with the low operand counting up from 0x00 and the high operand from 0x40. A misplaced byte, a swapped half or an off-by-one offset therefore shows as a wrong byte value and not as a coincidental match. Full count sweeps in both modes cover the pure low operand, every straddling offset, the pure high operand and the zero-filled region. Isolated large counts (33, 64, 128, 255) separate true range handling from modulo wrap. Random operands with nonzero upper halves in narrow mode show whether any upper-half bit reaches the result. Dense mixed streams of both widths, including a narrow operation two clocks after a wide one, expose latency, ordering and dropped or duplicated results.

// File: rtl/alignr_pkg.sv
package alignr_pkg;

    localparam int unsigned BYTE_BITS    = 8;
    localparam int unsigned COUNT_BITS   = 8;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic                  valid;
        op_mode_e              mode;
        logic [COUNT_BITS-1:0] count;
    } op_ctl_t;

    function automatic int unsigned fine_bits(input int unsigned gran);
        return (gran > 1) ? $clog2(gran) : 1;
    endfunction

endpackage

// File: rtl/alignr_byte_shift.sv
module alignr_byte_shift #(
    parameter int unsigned IN_BYTES  = 32,
    parameter int unsigned OUT_BYTES = 19,
    parameter int unsigned GRAN      = 4,
    parameter int unsigned SH_W      = 6
) (
    input  logic [IN_BYTES*8-1:0]  src,
    input  logic [SH_W-1:0]        shift,
    output logic [OUT_BYTES*8-1:0] dst
);
    localparam int unsigned IDX_W = SH_W + $clog2(GRAN + 1) + $clog2(OUT_BYTES + 1) + 1;
    localparam int unsigned SEL_W = $clog2(IN_BYTES);

    logic [IDX_W-1:0] base;
    assign base = IDX_W'(shift) * IDX_W'(GRAN);

    for (genvar i = 0; i < int'(OUT_BYTES); i++) begin : g_byte
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] sel;
        logic             in_range;
        assign idx      = base + IDX_W'(i);
        assign sel      = idx[SEL_W-1:0];
        assign in_range = (idx < IDX_W'(IN_BYTES));
        assign dst[8*i +: 8] = in_range ? src[{sel, 3'b000} +: 8] : 8'h00;
    end
endmodule

// File: rtl/alignr_wide_path.sv
module alignr_wide_path
    import alignr_pkg::*;
#(
    parameter int unsigned BYTES = 16,
    parameter int unsigned GRAN  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [COUNT_BITS-1:0]  count,
    input  logic [BYTES*8-1:0]     hi,
    input  logic [BYTES*8-1:0]     lo,
    output logic                   res_valid,
    output logic [BYTES*8-1:0]     res_data
);
    localparam int unsigned CAT_BYTES = 2 * BYTES;
    localparam int unsigned WIN_BYTES = BYTES + GRAN - 1;
    localparam int unsigned FINE_W    = fine_bits(GRAN);
    localparam int unsigned COARSE_W  = COUNT_BITS - FINE_W;

    logic [CAT_BYTES*8-1:0] cat;
    logic [WIN_BYTES*8-1:0] coarse_win;
    logic [WIN_BYTES*8-1:0] s1_win;
    logic [FINE_W-1:0]      s1_fine;
    logic                   s1_valid;
    logic [BYTES*8-1:0]     fine_out;

    assign cat = {hi, lo};

    // Stage one: move the window by whole groups of GRAN bytes.
    alignr_byte_shift #(
        .IN_BYTES (CAT_BYTES),
        .OUT_BYTES(WIN_BYTES),
        .GRAN     (GRAN),
        .SH_W     (COARSE_W)
    ) u_coarse (
        .src  (cat),
        .shift(count[COUNT_BITS-1:FINE_W]),
        .dst  (coarse_win)
    );

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            s1_valid <= 1'b0;
            s1_fine  <= '0;
            s1_win   <= '0;
        end else begin
            s1_valid <= 1'b1;
            s1_fine  <= count[FINE_W-1:0];
            s1_win   <= coarse_win;
        end
    end

    // Stage two: the remaining byte offset inside one group.
    alignr_byte_shift #(
        .IN_BYTES (WIN_BYTES),
        .OUT_BYTES(BYTES),
        .GRAN     (1),
        .SH_W     (FINE_W)
    ) u_fine (
        .src  (s1_win),
        .shift(s1_fine),
        .dst  (fine_out)
    );

    always_ff @(posedge clk) begin
        if (rst || !s1_valid) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b1;
            res_data  <= fine_out;
        end
    end
endmodule

// File: rtl/alignr_narrow_path.sv
module alignr_narrow_path
    import alignr_pkg::*;
#(
    parameter int unsigned BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [COUNT_BITS-1:0] count,
    input  logic [BYTES*8-1:0]    hi,
    input  logic [BYTES*8-1:0]    lo,
    output logic                  res_valid,
    output logic [BYTES*8-1:0]    res_data
);
    logic [2*BYTES*8-1:0] cat;
    logic [BYTES*8-1:0]   win;

    assign cat = {hi, lo};

    alignr_byte_shift #(
        .IN_BYTES (2 * BYTES),
        .OUT_BYTES(BYTES),
        .GRAN     (1),
        .SH_W     (COUNT_BITS)
    ) u_shift (
        .src  (cat),
        .shift(count),
        .dst  (win)
    );

    always_ff @(posedge clk) begin
        if (rst || !start) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b1;
            res_data  <= win;
        end
    end
endmodule

// File: rtl/alignr_unit.sv
module alignr_unit
    import alignr_pkg::*;
#(
    parameter int unsigned WIDE_BYTES   = 16,
    parameter int unsigned NARROW_BYTES = 8,
    parameter int unsigned COARSE_GRAN  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      in_mode,
    input  logic [COUNT_BITS-1:0]     in_count,
    input  logic [WIDE_BYTES*8-1:0]   in_hi,
    input  logic [WIDE_BYTES*8-1:0]   in_lo,
    output logic                      out_valid,
    output logic [WIDE_BYTES*8-1:0]   out_data
);
    localparam int unsigned WIDE_BITS   = WIDE_BYTES * 8;
    localparam int unsigned NARROW_BITS = NARROW_BYTES * 8;

    op_ctl_t                ctl;
    logic                   wide_start;
    logic                   narrow_start;
    logic                   wide_valid;
    logic [WIDE_BITS-1:0]   wide_data;
    logic                   narrow_valid;
    logic [NARROW_BITS-1:0] narrow_data;

    assign ctl = '{valid: in_valid, mode: op_mode_e'(in_mode), count: in_count};
    assign wide_start   = ctl.valid && (ctl.mode == MODE_WIDE);
    assign narrow_start = ctl.valid && (ctl.mode == MODE_NARROW);

    alignr_wide_path #(
        .BYTES(WIDE_BYTES),
        .GRAN (COARSE_GRAN)
    ) u_wide (
        .clk      (clk),
        .rst      (rst),
        .start    (wide_start),
        .count    (ctl.count),
        .hi       (in_hi),
        .lo       (in_lo),
        .res_valid(wide_valid),
        .res_data (wide_data)
    );

    alignr_narrow_path #(
        .BYTES(NARROW_BYTES)
    ) u_narrow (
        .clk      (clk),
        .rst      (rst),
        .start    (narrow_start),
        .count    (ctl.count),
        .hi       (in_hi[NARROW_BITS-1:0]),
        .lo       (in_lo[NARROW_BITS-1:0]),
        .res_valid(narrow_valid),
        .res_data (narrow_data)
    );

    always_comb begin
        out_valid = wide_valid || narrow_valid;
        if (wide_valid) begin
            out_data = wide_data;
        end else begin
            out_data = {{(WIDE_BITS - NARROW_BITS){1'b0}}, narrow_data};
        end
    end
endmodule

// File: rtl/alignr_unit_checker.sv
module alignr_unit_checker #(
    parameter int unsigned WIDE_BYTES   = 16,
    parameter int unsigned NARROW_BYTES = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_mode,
    input logic [7:0]              in_count,
    input logic                    out_valid,
    input logic [WIDE_BYTES*8-1:0] out_data
);
    localparam int unsigned NB = NARROW_BYTES * 8;

    // R2: wide result two edges after issue
    p_wide_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode) |-> ##2 out_valid);

    // R3: narrow result one edge after issue
    p_narrow_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode) |=> out_valid);

    // R4: narrow result upper half is zero
    p_narrow_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode) |=> (out_data[WIDE_BYTES*8-1:NB] == '0));

    // R5 and R6: out-of-range wide count gives zero
    p_far_count_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode && (in_count >= 8'(2 * WIDE_BYTES))) |-> ##2 (out_data == '0));

    // R5: out-of-range narrow count gives zero
    p_far_narrow_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode && (in_count >= 8'(2 * NARROW_BYTES))) |=> (out_data == '0));

    // R7: no result without a matching operation
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid && !in_mode) || $past(in_valid && in_mode, 2)));

    // R8: idle output is zero
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

    // R9: usage rule, no narrow op right after a wide op
    p_no_clash_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_mode) |-> !$past(in_valid && in_mode));
endmodule

bind alignr_unit alignr_unit_checker #(
    .WIDE_BYTES  (WIDE_BYTES),
    .NARROW_BYTES(NARROW_BYTES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_mode  (in_mode),
    .in_count (in_count),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/alignr_unit_bench.sv
module alignr_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_mode = 1'b0;
    logic [7:0]   in_count = 8'd0;
    logic [127:0] in_hi = '0;
    logic [127:0] in_lo = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;
    bit last_wide = 1'b0;

    logic [127:0] exp_data [int];
    string        exp_tag  [int];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    alignr_unit u_alignr_unit (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_mode  (in_mode),
        .in_count (in_count),
        .in_hi    (in_hi),
        .in_lo    (in_lo),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    function automatic logic [127:0] model(bit wide, int cnt, logic [127:0] hi, logic [127:0] lo);
        int w = wide ? 16 : 8;
        logic [127:0] r = '0;
        for (int i = 0; i < w; i++) begin
            int k = cnt + i;
            if (k < w)          r[8*i +: 8] = lo[8*k +: 8];
            else if (k < 2 * w) r[8*i +: 8] = hi[8*(k - w) +: 8];
            else                r[8*i +: 8] = 8'h00;
        end
        return r;
    endfunction

    function automatic logic [127:0] ramp(int start);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[8*i +: 8] = 8'(start + i);
        return v;
    endfunction

    // Cycle-by-cycle comparison against the scheduled expectations
    always @(negedge clk) begin
        if (checking) begin
            logic         ev;
            logic [127:0] ed;
            string        tg;
            if (exp_data.exists(cyc)) begin
                ev = 1'b1; ed = exp_data[cyc]; tg = exp_tag[cyc];
                exp_data.delete(cyc); exp_tag.delete(cyc);
            end else begin
                ev = 1'b0; ed = '0; tg = "R8";
            end
            checks++;
            if (out_valid !== ev || out_data !== ed) begin
                errors++;
                $display("FAIL %s cycle %0d: valid=%0b data=%h expected valid=%0b data=%h",
                         tg, cyc, out_valid, out_data, ev, ed);
            end
        end
    end

    task automatic issue(bit wide, int cnt, logic [127:0] hi, logic [127:0] lo, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = wide;
        in_count = 8'(cnt);
        in_hi    = hi;
        in_lo    = lo;
        exp_data[cyc + (wide ? 2 : 1)] = model(wide, cnt, hi, lo);
        exp_tag[cyc + (wide ? 2 : 1)]  = tag;
        last_wide = wide;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_count = $urandom;
            in_hi    = {$urandom, $urandom, $urandom, $urandom};
            in_lo    = {$urandom, $urandom, $urandom, $urandom};
            last_wide = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [127:0] lo_r;
        logic [127:0] hi_r;
        repeat (2) @(negedge clk);
        checking = 1'b1;          // R8: outputs checked during reset too
        repeat (2) @(negedge clk);
        rst = 1'b0;
        idle(3);                  // R8: reset state, idle output zero

        lo_r = ramp(8'h00);
        hi_r = ramp(8'h40);

        // R1, R5, R7: wide sweep, one op per clock
        for (int c = 0; c <= 34; c++) issue(1'b1, c, hi_r, lo_r, (c < 16) ? "R1" : (c < 32) ? "R5" : "R7");
        idle(3);

        // R3, R5: narrow sweep back to back
        for (int c = 0; c <= 18; c++) issue(1'b0, c, hi_r, lo_r, (c < 16) ? "R3" : "R5");
        idle(2);

        // R6: large counts never wrap
        issue(1'b1, 33, hi_r, lo_r, "R6");
        issue(1'b1, 255, hi_r, lo_r, "R6");
        issue(1'b1, 64, hi_r, lo_r, "R6");
        idle(1);
        issue(1'b0, 17, hi_r, lo_r, "R6");
        issue(1'b0, 128, hi_r, lo_r, "R6");
        issue(1'b0, 255, hi_r, lo_r, "R6");
        idle(2);

        // R4: narrow ops with busy upper halves
        for (int k = 0; k < 12; k++) begin
            logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
            issue(1'b0, $urandom_range(0, 16), a, b, "R4");
        end
        idle(2);

        // R9: narrow two clocks after wide, narrow then wide
        issue(1'b1, 5, hi_r, lo_r, "R9");
        idle(1);
        issue(1'b0, 3, hi_r, lo_r, "R9");
        issue(1'b1, 20, hi_r, lo_r, "R9");
        idle(3);

        // R2, R7: random mixed stream with legal spacing
        for (int k = 0; k < 400; k++) begin
            int sel = $urandom_range(0, 9);
            logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
            int cnt = (sel == 9) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 34));
            if (sel < 2) idle(1);
            else if (sel < 6 || last_wide) issue(1'b1, cnt, a, b, "R2");
            else issue(1'b0, cnt % 20, a, b, "R7");
        end
        idle(4);

        if (exp_data.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R7: %0d results never delivered, expected 0", exp_data.size());
        end
        finished = 1'b1;
        finish_run();
    end
endmodule